// File: doc/BRIEF.md
# Serial Flash DMA Burst Engine

This block moves a run of bytes between a serial flash byte stream and system memory, so that the processor never touches the individual bytes. Software loads a 32-bit memory start address and a length word that holds the byte count together with a lane-width code. It then writes a direction value to the trigger register. The engine packs or unpacks the bytes into 32-bit words and moves them through a simple single-outstanding memory master port.

The engine sits beside a shared serial shifter, which it reaches through two byte streams with valid/ready handshakes: one inbound from the flash and one outbound to it. The latched lane-width code is passed to the shifter for the whole transfer. Each trigger is capped at a direction-dependent length, so a long transfer is split into chunks, and software re-arms the engine for each chunk with a fresh address and length. A completion flag in the status register can raise an interrupt line when the enable bit in the config register is set. The flag is cleared by writing one to it.

Top module: `snand_dma_eng`

## Requirements
- R1: After reset every readable register (config 0x00, address 0x1c, status 0x20, length 0x24) reads zero, and busy_o, irq_o, mem_req_o, rx_ready_o, tx_valid_o and lane_o are all low.
- R2: Writing 0 to bit 0 of the trigger register (0x18) while idle starts a flash-to-memory transfer. Inbound bytes are packed four per word with the first byte in bits 31:24. Words are written to consecutive word addresses starting at the programmed address, and address bits 1:0 are ignored (mem_addr_o[1:0] is always 0).
- R3: A flash-to-memory write of a full word uses byte enables 4'b1111. A final word holding k bytes (k = 1, 2, 3) enables only the top k byte lanes: 4'b1000, 4'b1100 or 4'b1110.
- R4: Writing 1 to the trigger register while idle starts a memory-to-flash transfer. Words are read from consecutive addresses, and exactly the programmed number of bytes is sent, most significant byte of each word first. No word beyond the last needed one is read.
- R5: The byte count is taken from length bits 11:0, and the lane-width code from length bits 29:28. The lane code is latched at the trigger and driven on lane_o for the whole transfer.
- R6: A count above the cap for the chosen direction is clamped to that cap: 2080 bytes for flash-to-memory and 520 bytes for memory-to-flash.
- R7: Completion sets status bit 0. Writing 1 to that bit clears it, and writing 0 leaves it set. A count of zero completes with no memory access.
- R8: irq_o is high exactly when config bit 20 and status bit 0 are both set.
- R9: A trigger write while busy_o is high is ignored: the running transfer is neither restarted nor changed, and no second transfer follows it.
- R10: A memory request holds its address, write flag and write data stable until granted. An outbound byte holds its data stable until accepted.
- R11: busy_o rises in the cycle after an accepted trigger and falls in the same cycle the status flag is set. While it is low, no memory request, inbound ready or outbound valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| rx_valid_i | input | 1 | Inbound byte from shifter valid |
| rx_data_i | input | 8 | Inbound byte |
| rx_ready_o | output | 1 | Engine accepts inbound byte |
| tx_valid_o | output | 1 | Outbound byte valid |
| tx_data_o | output | 8 | Outbound byte |
| tx_ready_i | input | 1 | Shifter accepts outbound byte |
| lane_o | output | 2 | Latched lane-width code |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
A stale remaining-byte count is visible on the streams within one byte. On an inbound transfer, one byte too many or too few is accepted; on an outbound transfer, the wrong number of bytes arrives at the sink. A wrong pack slot or fill count corrupts a memory word or its enables at the first word write, and this shows as changed sentinel bytes in the memory model. A misdirected state sequence shows within the transfer as an extra or missing memory access, or as a busy flag that falls without the status bit being set.

// File: rtl/snand_dma_pkg.sv
package snand_dma_pkg;
  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_TRIG  = 8'h18;
  localparam logic [7:0] OFS_MADDR = 8'h1c;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_LEN   = 8'h24;
  localparam int IE_BIT   = 20;
  localparam int LANE_LSB = 28;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_WR, ST_RD, ST_RWAIT, ST_SEND, ST_FIN
  } dma_st_e;

  // enables for the leading n byte lanes, MSB lane first
  function automatic logic [3:0] lead_be(input logic [2:0] n);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[3-k] = (k < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/snand_dma_regs.sv
module snand_dma_regs
  import snand_dma_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             dir_o,
  output logic [31:0]      maddr_o,
  output logic [LEN_W-1:0] count_o,
  output logic [1:0]       lane_o,
  output logic             irq_o
);
  logic [31:0] cfg_q, maddr_q, len_q;
  logic        pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      maddr_q <= '0;
      len_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == OFS_CFG)   cfg_q   <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_MADDR) maddr_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_LEN)   len_q   <= reg_wdata_i;
      if (done_i) pend_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == OFS_STAT && reg_wdata_i[0]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_CFG:   reg_rdata_o = cfg_q;
      OFS_MADDR: reg_rdata_o = maddr_q;
      OFS_STAT:  reg_rdata_o = {31'b0, pend_q};
      OFS_LEN:   reg_rdata_o = len_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign start_o = reg_we_i && reg_addr_i == OFS_TRIG && !busy_i;
  assign dir_o   = reg_wdata_i[0];
  assign maddr_o = maddr_q;
  assign count_o = len_q[LEN_W-1:0];
  assign lane_o  = len_q[LANE_LSB+1:LANE_LSB];
  assign irq_o   = cfg_q[IE_BIT] & pend_q;
endmodule

// File: rtl/snand_dma_packer.sv
module snand_dma_packer #(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               push_i,
  input  logic [7:0]         byte_i,
  output logic [8*LANES-1:0] word_o,
  output logic [2:0]         fill_o
);
  logic [8*LANES-1:0] word_q;
  logic [2:0]         fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      fill_q <= '0;
    end else if (push_i) begin
      for (int k = 0; k < LANES; k++)
        if (fill_q == 3'(k)) word_q[8*(LANES-1-k) +: 8] <= byte_i;
      fill_q <= fill_q + 3'd1;
    end
  end

  assign word_o = word_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/snand_dma_unpacker.sv
module snand_dma_unpacker #(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [8*LANES-1:0] word_i,
  input  logic [2:0]         nb_i,
  input  logic               pop_i,
  output logic [7:0]         byte_o,
  output logic [2:0]         left_o
);
  logic [8*LANES-1:0] sh_q;
  logic [2:0]         left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= nb_i;
    end else if (pop_i) begin
      sh_q   <= {sh_q[8*LANES-9:0], 8'h00};
      left_q <= left_q - 3'd1;
    end
  end

  assign byte_o = sh_q[8*LANES-1 -: 8];
  assign left_o = left_q;
endmodule

// File: rtl/snand_dma_eng.sv
module snand_dma_eng
  import snand_dma_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int RD_CAP = 2080,
  parameter int WR_CAP = 520
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  output logic [1:0]  lane_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        busy_o,
  output logic        irq_o
);
  localparam logic [LEN_W-1:0] RD_LIM = LEN_W'(RD_CAP);
  localparam logic [LEN_W-1:0] WR_LIM = LEN_W'(WR_CAP);
  localparam logic [LEN_W-1:0] WORD_B = LEN_W'(4);

  dma_st_e          st_q;
  logic [LEN_W-1:0] rem_q, cap, eff_len, cnt_raw;
  logic [29:0]      ptr_q;
  logic [1:0]       lane_q, lane_raw;
  logic             start, dir, done;
  logic [31:0]      maddr, pword;
  logic [2:0]       fill, left, up_nb;
  logic             rx_fire, tx_fire, pk_clr, up_load;

  snand_dma_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy_o), .done_i(done), .start_o(start), .dir_o(dir),
    .maddr_o(maddr), .count_o(cnt_raw), .lane_o(lane_raw), .irq_o
  );

  snand_dma_packer #(.LANES(4)) u_pack (
    .clk_i, .rst_ni, .clr_i(pk_clr), .push_i(rx_fire), .byte_i(rx_data_i),
    .word_o(pword), .fill_o(fill)
  );

  snand_dma_unpacker #(.LANES(4)) u_unpack (
    .clk_i, .rst_ni, .load_i(up_load), .word_i(mem_rdata_i), .nb_i(up_nb),
    .pop_i(tx_fire), .byte_o(tx_data_o), .left_o(left)
  );

  assign cap     = dir ? WR_LIM : RD_LIM;
  assign eff_len = (cnt_raw > cap) ? cap : cnt_raw;

  assign rx_ready_o  = (st_q == ST_FILL) && (fill < 3'd4) && (rem_q != '0);
  assign rx_fire     = rx_ready_o && rx_valid_i;
  assign tx_valid_o  = (st_q == ST_SEND) && (left != 3'd0);
  assign tx_fire     = tx_valid_o && tx_ready_i;
  assign mem_req_o   = (st_q == ST_WR) || (st_q == ST_RD);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = {ptr_q, 2'b00};
  assign mem_wdata_o = pword;
  assign mem_be_o    = mem_we_o ? lead_be(fill) : 4'hF;
  assign pk_clr      = (st_q == ST_WR) && mem_gnt_i;
  assign up_load     = (st_q == ST_RWAIT) && mem_rvalid_i;
  assign up_nb       = (rem_q >= WORD_B) ? 3'd4 : rem_q[2:0];
  assign done        = (st_q == ST_FIN);
  assign busy_o      = (st_q != ST_IDLE);
  assign lane_o      = lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      ptr_q  <= '0;
      lane_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          ptr_q  <= maddr[31:2];
          rem_q  <= eff_len;
          lane_q <= lane_raw;
          if (eff_len == '0) st_q <= ST_FIN;
          else               st_q <= dir ? ST_RD : ST_FILL;
        end
        ST_FILL: begin
          if (rx_fire) rem_q <= rem_q - 1'b1;
          if (fill == 3'd4 || (rem_q == '0 && fill != 3'd0)) st_q <= ST_WR;
        end
        ST_WR: if (mem_gnt_i) begin
          ptr_q <= ptr_q + 30'd1;
          st_q  <= (rem_q == '0) ? ST_FIN : ST_FILL;
        end
        ST_RD: if (mem_gnt_i) st_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid_i) begin
          ptr_q <= ptr_q + 30'd1;
          st_q  <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_fire) rem_q <= rem_q - 1'b1;
          if (left == 3'd0) st_q <= (rem_q == '0) ? ST_FIN : ST_RD;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snand_dma_chk.sv
module snand_dma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic [3:0]  mem_be_o,
  input logic        rx_ready_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [7:0]  tx_data_o,
  input logic [1:0]  lane_o
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_addr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_be_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o inside {4'b1000, 4'b1100, 4'b1110, 4'b1111});

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rx_ready_o && !tx_valid_o);

  p_one_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && tx_valid_o));

  p_lane_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(lane_o));
endmodule

bind snand_dma_eng snand_dma_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .rx_ready_o(rx_ready_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .lane_o(lane_o)
);

// File: tb/snand_dma_eng_tb.sv
module snand_dma_eng_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_valid, rx_ready, tx_valid, tx_ready;
  logic [7:0]  rx_data, tx_data;
  logic [1:0]  lane;
  logic        mem_req, mem_we, mem_gnt, busy, irq;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  always #2 clk = ~clk;

  snand_dma_eng u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_ready_i(tx_ready), .lane_o(lane),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .busy_o(busy), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0]  gcnt = '0;
  logic [31:0] mem [0:1023];
  int          acc_cnt = 0;
  logic        src_on = 0, snk_on = 0;
  int          src_idx = 0, got_n = 0;
  logic [7:0]  src_seed = '0;
  logic [7:0]  got [0:1023];

  always @(posedge clk) gcnt <= gcnt + 4'd1;

  // memory model: grant stalls on a pattern, read data one cycle after grant
  assign mem_gnt = mem_req & (gcnt[1:0] != 2'b01);
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
  end

  assign rx_valid = src_on & (gcnt[2:0] != 3'd3);
  assign rx_data  = src_seed + 8'(src_idx * 13);
  always @(posedge clk) if (rx_valid && rx_ready) src_idx <= src_idx + 1;

  assign tx_ready = snk_on & (gcnt[1:0] != 2'b10);
  always @(posedge clk) if (tx_valid && tx_ready) begin
    got[got_n] <= tx_data;
    got_n <= got_n + 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(32'(busy), 32'd0, tag);
  endtask

  function automatic logic [7:0] fb(input logic [7:0] seed, input int k);
    return seed + 8'(k * 13);
  endfunction

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ex;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5A5A5;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk(d, 0, "R1 cfg");
    rd(8'h1c, d); chk(d, 0, "R1 maddr");
    rd(8'h20, d); chk(d, 0, "R1 stat");
    rd(8'h24, d); chk(d, 0, "R1 len");
    chk({26'b0, busy, irq, mem_req, rx_ready, tx_valid, 1'b0}, 0, "R1 outputs");
    chk(32'(lane), 0, "R1 lane");

    // flash-to-memory sweep, lengths 0..9, misaligned start addresses
    for (int n = 0; n <= 9; n++) begin
      int bw;
      bit ie;
      bw = 600 + 12 * n;
      ie = (n % 2 == 0);
      for (int w = 0; w < 5; w++) mem[bw + w] = 32'hA5A5A5A5;
      src_idx = 0; src_seed = 8'(n * 31); src_on = 1;
      wr(8'h00, 32'(ie) << 20);
      wr(8'h1c, 32'(bw * 4 + n % 4));
      wr(8'h24, (32'(n % 4) << 28) | 32'(n));
      acc_cnt = 0;
      wr(8'h18, 32'd0);
      chk(32'(busy), 1, "R11 busy after trigger");
      chk(32'(lane), 32'(n % 4), "R5 lane latched");
      wait_idle("R11 rx idle");
      repeat (2) @(negedge clk);
      chk(32'(src_idx), 32'(n), "R2 bytes accepted");
      chk(32'(acc_cnt), 32'((n + 3) / 4), "R7 rx access count");
      for (int w = 0; w < 4; w++) begin
        ex = 32'hA5A5A5A5;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < n) ex[8*(3-b) +: 8] = fb(8'(n * 31), w * 4 + b);
        chk(mem[bw + w], ex, "R2 R3 packed word");
      end
      rd(8'h20, d); chk(d, 1, "R7 pend set");
      chk(32'(irq), 32'(ie), "R8 irq gate");
      wr(8'h20, 32'd0);
      rd(8'h20, d); chk(d, 1, "R7 zero write keeps pend");
      wr(8'h20, 32'd1);
      rd(8'h20, d); chk(d, 0, "R7 w1c");
      chk(32'(irq), 0, "R8 irq low after clear");
      src_on = 0;
    end

    // memory-to-flash sweep, lengths 1..9
    snk_on = 1;
    for (int n = 1; n <= 9; n++) begin
      int bw;
      bw = 200 + 12 * n;
      for (int w = 0; w < 4; w++) mem[bw + w] = 32'h1000_0000 * (w + 1) + 32'(n * 4099 + w * 77);
      got_n = 0;
      wr(8'h1c, 32'(bw * 4));
      wr(8'h24, (32'(3 - n % 4) << 28) | 32'(n));
      acc_cnt = 0;
      wr(8'h18, 32'd1);
      chk(32'(lane), 32'(3 - n % 4), "R5 lane tx");
      wait_idle("R11 tx idle");
      repeat (2) @(negedge clk);
      chk(32'(got_n), 32'(n), "R4 byte count");
      chk(32'(acc_cnt), 32'((n + 3) / 4), "R4 reads");
      for (int k = 0; k < n; k++) begin
        ex = mem[bw + k / 4];
        chk(32'(got[k]), 32'(ex[8*(3-k%4) +: 8]), "R4 byte order");
      end
      wr(8'h20, 32'd1);
    end

    // R6 clamp, read direction
    src_idx = 0; src_seed = 8'h11; src_on = 1;
    wr(8'h1c, 32'd0);
    wr(8'h24, 32'd3000);
    acc_cnt = 0;
    wr(8'h18, 32'd0);
    wait_idle("R6 rx idle");
    repeat (2) @(negedge clk);
    chk(32'(src_idx), 2080, "R6 read cap bytes");
    chk(32'(acc_cnt), 520, "R6 read cap words");
    ex = {fb(8'h11, 2076), fb(8'h11, 2077), fb(8'h11, 2078), fb(8'h11, 2079)};
    chk(mem[519], ex, "R6 last word");
    src_on = 0;
    wr(8'h20, 32'd1);

    // R6 clamp, write direction
    got_n = 0;
    wr(8'h1c, 32'd0);
    wr(8'h24, 32'd1000);
    wr(8'h18, 32'd1);
    wait_idle("R6 tx idle");
    repeat (2) @(negedge clk);
    chk(32'(got_n), 520, "R6 write cap");
    wr(8'h20, 32'd1);

    // R9 trigger while busy is ignored
    src_idx = 0; src_seed = 8'h42; got_n = 0;
    wr(8'h1c, 32'(900 * 4));
    wr(8'h24, 32'd12);
    acc_cnt = 0;
    wr(8'h18, 32'd0);
    wr(8'h24, 32'd5);
    wr(8'h18, 32'd1);
    wr(8'h18, 32'd0);
    src_on = 1;
    wait_idle("R9 idle");
    repeat (4) @(negedge clk);
    chk(32'(busy), 0, "R9 no second transfer");
    chk(32'(src_idx), 12, "R9 length unchanged");
    chk(32'(got_n), 0, "R9 no outbound bytes");
    chk(32'(acc_cnt), 3, "R9 access count");
    chk(mem[902], {fb(8'h42, 8), fb(8'h42, 9), fb(8'h42, 10), fb(8'h42, 11)}, "R9 data");
    src_on = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule